// File: doc/BRIEF.md
# Integer-N Synthesizer Divider Programming Port

This block captures the divider settings of an integer-N frequency synthesizer and presents them to the feedback and reference counters. Software or a host controller can program it in one of three ways that share the same pins: a bit-serial stream clocked in by a slow serial clock, byte-wide strobed writes that each fill a slice of a 20-bit staging word, or a direct mode where the counter values come straight from dedicated input buses.

The staging word (called the primary word here) can be copied into a second, holding word (the secondary word) by a hop strobe, or by the end of a serial frame. A frame-select input then decides whether the counters see the primary or the secondary copy. This lets a new setting be loaded in the background and applied on one edge. An 8-bit enhancement register can be loaded either serially or by a strobe. All external strobes and the serial clock are brought into one system clock through two-flop synchronisers. Each is acted on at its rising edge, so the whole block is synchronous.

Top module: `synth_prog_if`

## Requirements
- R1: After reset the primary, secondary and enhancement words are all zero, so in serial or parallel mode every counter output is 0, `pre_en_n` is 0, `pre_bypass` is 0 and `enh_q` is 0.
- R2: In serial mode (`mode_dir`=0, `mode_ser`=1), each rising edge of `ser_clk` taken while `ser_ld_n` is low and `enh_sel` is low shifts `ser_dat` into bit 0 of the primary word, moving the other bits up. Data therefore enters MSB first. The bit order from bit 19 down to bit 0 is prescaler-enable, M[8:0], R[5:0], A[3:0]. Bits pushed past bit 19 are lost, so a frame longer than 20 bits keeps only its last 20 bits.
- R3: In serial mode, while `enh_sel` is high, the same shifting goes MSB first into the 8-bit enhancement register and leaves the primary word unchanged.
- R4: The primary word is copied into the secondary word on a rising edge of `ser_ld_n` in serial mode, or on a rising edge of `hop_stb` in serial or parallel mode. No other event changes the secondary word.
- R5: In parallel mode (`mode_dir`=0, `mode_ser`=0), a rising edge of `m1_stb` loads `par_d[7]` into prescaler-enable and `par_d[6:0]` into M[6:0].
- R6: In parallel mode, a rising edge of `m2_stb` loads `par_d[3:2]` into R[5:4] and `par_d[1:0]` into M[8:7].
- R7: In parallel mode, a rising edge of `a_stb` loads `par_d[7:4]` into R[3:0] and `par_d[3:0]` into A[3:0].
- R8: In parallel mode, a rising edge of `enh_sel` loads `par_d[7:0]` into the enhancement register. In serial mode, `ser_ld_n` edges have no effect on the enhancement register, and in parallel mode `ser_clk` and `ser_ld_n` have no effect on any register.
- R9: `mode_dir`=1 selects direct mode whatever `mode_ser` is. Otherwise `mode_ser` picks serial (1) or parallel (0) mode.
- R10: In serial mode `fsel_ser` chooses the source of the counter outputs, and in parallel mode `fsel_par` does. A value of 1 selects the primary word and 0 selects the secondary word.
- R11: `pre_bypass` equals the active-low prescaler enable `pre_en_n`.
- R12: In direct mode `m_cnt`=`dir_m`, `a_cnt`=`dir_a`, `r_cnt`=0 and `pre_en_n`=`dir_pre_n`. All strobes and serial activity are ignored, so the primary, secondary and enhancement words keep their values.
- R13: A strobe or serial-clock rise that goes high just after a clock edge takes effect at the third following clock edge. Falling edges have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dir | input | 1 | Direct-mode select (static) |
| mode_ser | input | 1 | Serial (1) / parallel (0) select when not direct (static) |
| fsel_ser | input | 1 | Frame select used in serial mode |
| fsel_par | input | 1 | Frame select used in parallel mode |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_ld_n | input | 1 | Serial load enable, active low; its rise ends a frame |
| enh_sel | input | 1 | Serial: enhancement target level; parallel: enhancement write strobe |
| m1_stb | input | 1 | Parallel write strobe for prescaler enable and M[6:0] |
| m2_stb | input | 1 | Parallel write strobe for R[5:4] and M[8:7] |
| a_stb | input | 1 | Parallel write strobe for R[3:0] and A[3:0] |
| hop_stb | input | 1 | Primary-to-secondary copy strobe |
| par_d | input | 8 | Parallel data byte |
| dir_m | input | 9 | Direct-mode M counter value |
| dir_a | input | 4 | Direct-mode A counter value |
| dir_pre_n | input | 1 | Direct-mode prescaler enable, active low |
| m_cnt | output | 9 | M counter setting |
| a_cnt | output | 4 | A counter setting |
| r_cnt | output | 6 | R counter setting |
| pre_en_n | output | 1 | Prescaler enable, active low |
| pre_bypass | output | 1 | Prescaler bypass (high when the prescaler is disabled) |
| enh_q | output | 8 | Enhancement register contents |

## Verification
The assertions assume that the mode pins stay steady while strobes move, and that `ser_dat` and `par_d` are stable from the strobe's rise until the synchronised edge has acted three clocks later. They also assume strobe pulses and gaps each last several system clocks, so no edge is lost in the synchronisers. The stimulus changes the mode pins only while every strobe is idle. It holds each strobe and serial-clock level for four clocks and changes data only while the matching strobe is low. This keeps every capture well inside the window the checks rely on.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  parameter int W_M   = 9;
  parameter int W_A   = 4;
  parameter int W_R   = 6;
  parameter int W_ENH = 8;
  parameter int W_D   = 8;
  localparam int W_PRIM = 1 + W_M + W_R + W_A;
  localparam int A_LO   = 0;
  localparam int R_LO   = W_A;
  localparam int M_LO   = W_A + W_R;
  localparam int PRE_B  = W_PRIM - 1;

  // indices into the synchronised strobe vector
  localparam int N_SYNC = 7;
  localparam int IX_SCLK = 0;
  localparam int IX_LD   = 1;
  localparam int IX_ENH  = 2;
  localparam int IX_M1   = 3;
  localparam int IX_M2   = 4;
  localparam int IX_A    = 5;
  localparam int IX_HOP  = 6;

  typedef enum logic [1:0] {MODE_PAR = 2'd0, MODE_SER = 2'd1, MODE_DIR = 2'd2} load_mode_e;

  function automatic load_mode_e pick_mode(input logic dir, input logic ser);
    if (dir) return MODE_DIR;
    return ser ? MODE_SER : MODE_PAR;
  endfunction
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= raw[g];
        s2 <= s1;
      end
    end
    assign lvl[g] = s2;
  end
endmodule

// File: rtl/sp_rise.sv
module sp_rise #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end
  assign rise = lvl & ~prev;
endmodule

// File: rtl/sp_word_regs.sv
module sp_word_regs
  import synth_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_go,
  input  logic              ser_dat,
  input  logic              m1_go,
  input  logic              m2_go,
  input  logic              a_go,
  input  logic              copy_go,
  input  logic [W_D-1:0]    par_d,
  output logic [W_PRIM-1:0] prim_q,
  output logic [W_PRIM-1:0] sec_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_q <= '0;
    end else if (shift_go) begin
      prim_q <= {prim_q[W_PRIM-2:0], ser_dat};
    end else begin
      if (m1_go) begin
        prim_q[PRE_B]          <= par_d[7];
        prim_q[M_LO+6 : M_LO]  <= par_d[6:0];
      end
      if (m2_go) begin
        prim_q[R_LO+5 : R_LO+4] <= par_d[3:2];
        prim_q[M_LO+8 : M_LO+7] <= par_d[1:0];
      end
      if (a_go) begin
        prim_q[R_LO+3 : R_LO] <= par_d[7:4];
        prim_q[A_LO+3 : A_LO] <= par_d[3:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sec_q <= '0;
    else if (copy_go) sec_q <= prim_q;
  end
endmodule

// File: rtl/sp_enh_reg.sv
module sp_enh_reg
  import synth_prog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_go,
  input  logic             ser_dat,
  input  logic             par_go,
  input  logic [W_D-1:0]   par_d,
  output logic [W_ENH-1:0] enh_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        enh_q <= '0;
    else if (shift_go) enh_q <= {enh_q[W_ENH-2:0], ser_dat};
    else if (par_go)   enh_q <= par_d[W_ENH-1:0];
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_dir,
  input  logic             mode_ser,
  input  logic             fsel_ser,
  input  logic             fsel_par,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_ld_n,
  input  logic             enh_sel,
  input  logic             m1_stb,
  input  logic             m2_stb,
  input  logic             a_stb,
  input  logic             hop_stb,
  input  logic [W_D-1:0]   par_d,
  input  logic [W_M-1:0]   dir_m,
  input  logic [W_A-1:0]   dir_a,
  input  logic             dir_pre_n,
  output logic [W_M-1:0]   m_cnt,
  output logic [W_A-1:0]   a_cnt,
  output logic [W_R-1:0]   r_cnt,
  output logic             pre_en_n,
  output logic             pre_bypass,
  output logic [W_ENH-1:0] enh_q
);
  logic [N_SYNC-1:0] raw_in, lvl, rise;
  logic [W_PRIM-1:0] prim_q, sec_q, word_sel;
  load_mode_e mode;
  logic is_ser, is_par, shift_any, prim_shift, enh_shift, copy_go;
  logic m1_go, m2_go, a_go, enh_par_go;

  always_comb begin
    raw_in          = '0;
    raw_in[IX_SCLK] = ser_clk;
    raw_in[IX_LD]   = ser_ld_n;
    raw_in[IX_ENH]  = enh_sel;
    raw_in[IX_M1]   = m1_stb;
    raw_in[IX_M2]   = m2_stb;
    raw_in[IX_A]    = a_stb;
    raw_in[IX_HOP]  = hop_stb;
  end

  sp_sync #(.N(N_SYNC)) u_sync (.clk(clk), .rst_n(rst_n), .raw(raw_in), .lvl(lvl));
  sp_rise #(.N(N_SYNC)) u_rise (.clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise));

  assign mode   = pick_mode(mode_dir, mode_ser);
  assign is_ser = (mode == MODE_SER);
  assign is_par = (mode == MODE_PAR);

  assign shift_any  = is_ser & rise[IX_SCLK] & ~lvl[IX_LD];
  assign prim_shift = shift_any & ~lvl[IX_ENH];
  assign enh_shift  = shift_any &  lvl[IX_ENH];
  assign m1_go      = is_par & rise[IX_M1];
  assign m2_go      = is_par & rise[IX_M2];
  assign a_go       = is_par & rise[IX_A];
  assign enh_par_go = is_par & rise[IX_ENH];
  assign copy_go    = (is_ser & rise[IX_LD]) | ((is_ser | is_par) & rise[IX_HOP]);

  sp_word_regs u_words (
    .clk(clk), .rst_n(rst_n), .shift_go(prim_shift), .ser_dat(ser_dat),
    .m1_go(m1_go), .m2_go(m2_go), .a_go(a_go), .copy_go(copy_go),
    .par_d(par_d), .prim_q(prim_q), .sec_q(sec_q)
  );

  sp_enh_reg u_enh (
    .clk(clk), .rst_n(rst_n), .shift_go(enh_shift), .ser_dat(ser_dat),
    .par_go(enh_par_go), .par_d(par_d), .enh_q(enh_q)
  );

  always_comb begin
    word_sel = (is_ser ? fsel_ser : fsel_par) ? prim_q : sec_q;
    if (mode == MODE_DIR) begin
      m_cnt    = dir_m;
      a_cnt    = dir_a;
      r_cnt    = '0;
      pre_en_n = dir_pre_n;
    end else begin
      m_cnt    = word_sel[M_LO +: W_M];
      a_cnt    = word_sel[A_LO +: W_A];
      r_cnt    = word_sel[R_LO +: W_R];
      pre_en_n = word_sel[PRE_B];
    end
  end

  assign pre_bypass = pre_en_n;
endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk
  import synth_prog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mode_dir,
  input logic              ser_dat,
  input logic [W_M-1:0]    dir_m,
  input logic [W_A-1:0]    dir_a,
  input logic [W_M-1:0]    m_cnt,
  input logic [W_A-1:0]    a_cnt,
  input logic [W_R-1:0]    r_cnt,
  input logic [W_ENH-1:0]  enh_q,
  input logic [W_PRIM-1:0] prim_q,
  input logic [W_PRIM-1:0] sec_q,
  input logic              prim_shift,
  input logic              enh_shift,
  input logic              copy_go
);
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_go |=> $stable(sec_q)); // R4
  AST_SEC_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    copy_go |=> (sec_q == $past(prim_q))); // R4
  AST_SHIFT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    prim_shift |=> (prim_q == {$past(prim_q[W_PRIM-2:0]), $past(ser_dat)})); // R2
  AST_ENH_KEEPS_PRIM: assert property (@(posedge clk) disable iff (!rst_n)
    enh_shift |=> $stable(prim_q)); // R3
  AST_DIRECT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_dir |-> (m_cnt == dir_m && a_cnt == dir_a && r_cnt == '0)); // R12
  AST_DIRECT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_dir && $past(mode_dir)) |-> ($stable(prim_q) && $stable(enh_q) && $stable(sec_q))); // R12
endmodule

bind synth_prog_if synth_prog_if_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_dir(mode_dir), .ser_dat(ser_dat),
  .dir_m(dir_m), .dir_a(dir_a), .m_cnt(m_cnt), .a_cnt(a_cnt), .r_cnt(r_cnt),
  .enh_q(enh_q), .prim_q(prim_q), .sec_q(sec_q),
  .prim_shift(prim_shift), .enh_shift(enh_shift), .copy_go(copy_go)
);

// File: tb/synth_prog_if_tb_top.sv
module synth_prog_if_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_dir = 1'b0, mode_ser = 1'b0, fsel_ser = 1'b0, fsel_par = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld_n = 1'b1, enh_sel = 1'b0;
  logic m1_stb = 1'b0, m2_stb = 1'b0, a_stb = 1'b0, hop_stb = 1'b0;
  logic [7:0] par_d = '0;
  logic [8:0] dir_m = '0;
  logic [3:0] dir_a = '0;
  logic dir_pre_n = 1'b0;
  logic [8:0] m_cnt;
  logic [3:0] a_cnt;
  logic [5:0] r_cnt;
  logic pre_en_n, pre_bypass;
  logic [7:0] enh_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [19:0] e_prim = '0, e_sec = '0;
  logic [7:0]  e_enh = '0;

  always #2 clk = ~clk;

  synth_prog_if dut_i (
    .clk(clk), .rst_n(rst_n), .mode_dir(mode_dir), .mode_ser(mode_ser),
    .fsel_ser(fsel_ser), .fsel_par(fsel_par), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_ld_n(ser_ld_n), .enh_sel(enh_sel), .m1_stb(m1_stb), .m2_stb(m2_stb),
    .a_stb(a_stb), .hop_stb(hop_stb), .par_d(par_d), .dir_m(dir_m), .dir_a(dir_a),
    .dir_pre_n(dir_pre_n), .m_cnt(m_cnt), .a_cnt(a_cnt), .r_cnt(r_cnt),
    .pre_en_n(pre_en_n), .pre_bypass(pre_bypass), .enh_q(enh_q)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] outs();
    return {12'd0, pre_en_n, m_cnt, r_cnt, a_cnt};
  endfunction

  // 0:m1 1:m2 2:a 3:hop 4:enh
  task automatic pulse(input int which);
    case (which)
      0: m1_stb = 1'b1;
      1: m2_stb = 1'b1;
      2: a_stb = 1'b1;
      3: hop_stb = 1'b1;
      default: enh_sel = 1'b1;
    endcase
    tick(4);
    m1_stb = 1'b0; m2_stb = 1'b0; a_stb = 1'b0; hop_stb = 1'b0; enh_sel = 1'b0;
    tick(4);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i];
      tick(1);
      ser_clk = 1'b1;
      tick(4);
      ser_clk = 1'b0;
      tick(4);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d1, d2, d3;
    logic [31:0] w;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    fsel_par = 1'b1;
    tick(1);
    check("R1 prim", outs(), 32'd0);
    fsel_par = 1'b0;
    tick(1);
    check("R1 sec", outs(), 32'd0);
    check("R1 bypass", {31'd0, pre_bypass}, 32'd0);
    check("R1 enh", {24'd0, enh_q}, 32'd0);

    // parallel sweep: R5 R6 R7 R10 R4 R11
    for (int k = 0; k < 16; k++) begin
      d1 = 8'(k * 37 + 3);
      d2 = 8'(k);
      d3 = 8'(k * 13 + 5);
      par_d = d1; tick(1); pulse(0);
      par_d = d2; tick(1); pulse(1);
      par_d = d3; tick(1); pulse(2);
      e_prim = {d1[7], d2[1:0], d1[6:0], d2[3:2], d3[7:4], d3[3:0]};
      fsel_par = 1'b1; tick(1);
      check("R5 R6 R7 primary fields", outs(), {12'd0, e_prim});
      check("R11 bypass", {31'd0, pre_bypass}, {31'd0, e_prim[19]});
      fsel_par = 1'b0; tick(1);
      check("R10 secondary before hop", outs(), {12'd0, e_sec});
      pulse(3);
      e_sec = e_prim;
      check("R4 hop copy", outs(), {12'd0, e_sec});
    end

    // R13 latency: hop acts at third edge
    par_d = 8'hA5; tick(1); pulse(0);
    e_prim[19] = 1'b1; e_prim[16:10] = 7'h25;
    fsel_par = 1'b0;
    hop_stb = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R13 not yet copied", outs(), {12'd0, e_sec});
    @(posedge clk); @(negedge clk);
    check("R13 copied on third edge", outs(), {12'd0, e_prim});
    e_sec = e_prim;
    tick(3); hop_stb = 1'b0; tick(6);
    check("R13 falling edge no effect", outs(), {12'd0, e_sec});

    // R8 parallel enhancement write; serial pins ignored in parallel
    par_d = 8'h3C; tick(1); pulse(4);
    e_enh = 8'h3C;
    check("R8 enh strobe", {24'd0, enh_q}, {24'd0, e_enh});
    ser_ld_n = 1'b0; tick(2);
    send_bits(32'h5, 3);
    ser_ld_n = 1'b1; tick(6);
    fsel_par = 1'b1; tick(1);
    check("R8 serial ignored in parallel prim", outs(), {12'd0, e_prim});
    fsel_par = 1'b0; tick(1);
    check("R8 serial ignored in parallel sec", outs(), {12'd0, e_sec});

    // serial sweep: R2 R4 R9 R10
    mode_ser = 1'b1; tick(2);
    for (int k = 0; k < 8; k++) begin
      w = (32'(k) * 32'h1357B + 32'h9E3) & 32'hFFFFF;
      ser_ld_n = 1'b0; tick(2);
      send_bits(w, 20);
      e_prim = w[19:0];
      fsel_ser = 1'b1; tick(1);
      check("R2 serial primary", outs(), {12'd0, e_prim});
      fsel_ser = 1'b0; tick(1);
      check("R10 serial secondary", outs(), {12'd0, e_sec});
      ser_ld_n = 1'b1; tick(6);
      e_sec = e_prim;
      check("R4 load-enable rise copies", outs(), {12'd0, e_sec});
    end

    // R2 overlong frame keeps last 20 bits
    ser_ld_n = 1'b0; tick(2);
    send_bits(32'h5ABCDE, 23);
    e_prim = 20'hABCDE;
    fsel_ser = 1'b1; tick(1);
    check("R2 overlong frame", outs(), {12'd0, e_prim});

    // R3 serial into enhancement register
    enh_sel = 1'b1; tick(3);
    send_bits(32'hC6, 8);
    e_enh = 8'hC6;
    check("R3 enh serial", {24'd0, enh_q}, {24'd0, e_enh});
    check("R3 primary kept", outs(), {12'd0, e_prim});
    enh_sel = 1'b0; tick(3);
    ser_ld_n = 1'b1; tick(6);
    e_sec = e_prim;
    check("R8 enh unchanged by load-enable", {24'd0, enh_q}, {24'd0, e_enh});

    // R12 direct mode, R9 dir overrides mode_ser
    mode_dir = 1'b1;
    for (int k = 0; k < 4; k++) begin
      dir_m = 9'(k * 111 + 7);
      dir_a = 4'(k * 5 + 1);
      dir_pre_n = k[0];
      tick(2);
      check("R12 R9 direct outputs", outs(), {12'd0, dir_pre_n, dir_m, 6'd0, dir_a});
      check("R11 direct bypass", {31'd0, pre_bypass}, {31'd0, dir_pre_n});
    end
    ser_ld_n = 1'b0; tick(2);
    send_bits(32'h3, 4);
    ser_ld_n = 1'b1; tick(4);
    par_d = 8'hFF; tick(1);
    for (int s = 0; s < 5; s++) pulse(s);
    mode_dir = 1'b0; mode_ser = 1'b0; tick(2);
    check("R12 enh ignored in direct", {24'd0, enh_q}, {24'd0, e_enh});
    fsel_par = 1'b1; tick(1);
    check("R12 primary ignored in direct", outs(), {12'd0, e_prim});
    fsel_par = 1'b0; tick(1);
    check("R12 secondary ignored in direct", outs(), {12'd0, e_sec});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule